// File: doc/BRIEF.md
# Shared-Pin Test and Programming Port

This block sits between four shared serial pins and the rest of a chip. When `mode_sel` is high, the pins form a standard boundary-scan port. The control pin steps a sixteen-state test controller, `sdi` feeds scan data, `sclk` is the test clock and `so` returns scan data. Three instructions are decoded:

- SAMPLE observes the pins while the core keeps driving them.
- EXTEST drives the pins from latches loaded through the scan chain.
- BYPASS connects a single-bit path.

The boundary chain has one cell for each input-only pin and three cells for each tri-state pin: pad input, core output and core enable.

When `mode_sel` is low, the same pins feed a plain serial shift register that carries programming data. A high-to-low transition of `mode_sel` also places the chip in programming mode, which pulls every pad output enable low. Programming mode lasts until `mode_sel` returns high. The test reset does not clear it. While the pins serve the programming path, the test controller and its instruction are frozen.

Top module: `dual_test_port`

## Requirements
- R1: While `trst_n` is low, the test controller is held in Test-Logic-Reset, the instruction becomes BYPASS and `so_oe` is low. After release, `pad_out`/`pad_oe` follow `core_out`/`core_oe`, and a data scan shows a one-bit path that captures 0.
- R2: Five rising `sclk` edges with `ctl` high and `mode_sel` high return the controller to Test-Logic-Reset from any state, and the instruction becomes BYPASS.
- R3: The instruction register is 2 bits wide and is shifted least significant bit first. Capture-IR loads binary 01. Codes: 00 is EXTEST, 01 is SAMPLE, 11 is BYPASS.
- R4: Code 10, which is not defined, behaves exactly as BYPASS: a one-bit data path that captures 0, with pads following the core.
- R5: Under SAMPLE, Capture-DR loads the boundary chain and Shift-DR shifts it from `sdi` to `so`, while `pad_out`/`pad_oe` keep following the core.
- R6: Under EXTEST, `pad_out` and `pad_oe` come from the update latches, which are loaded from the chain in Update-DR.
- R7: Chain layout: bit 0 is next to `so` and is shifted out first, and the bit shifted in i-th ends at bit i. Input-only pin k is at bit k. Tri-state pin j uses bit N_IN+3j for the pad input, N_IN+3j+1 for the core output and N_IN+3j+2 for the core enable.
- R8: With `mode_sel` high, `so` changes on falling `sclk` edges, and `so_oe` is high only while the controller is in Shift-DR or Shift-IR.
- R9: With `mode_sel` low and `ctl` high, each rising `sclk` edge shifts the programming register right: `sdi` enters the top bit and `so` shows bit 0. `ctl` low holds the register. `so_oe` is high.
- R10: From the first rising `sclk` edge after `mode_sel` falls, every `pad_oe` bit is low until `mode_sel` is high again. Asserting `trst_n` meanwhile does not release it.
- R11: While `mode_sel` is low, the controller state and instruction do not change. After `mode_sel` returns high, the instruction loaded before is still in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_sel | input | 1 | High: boundary-scan use of the pins; low: programming path; falling edge enters programming mode |
| trst_n | input | 1 | Active-low asynchronous reset of the test logic |
| sclk | input | 1 | Shared test clock / programming shift clock |
| ctl | input | 1 | Test mode select, or programming shift enable |
| sdi | input | 1 | Serial data in for both uses |
| so | output | 1 | Serial data out for both uses |
| so_oe | output | 1 | Output enable for `so` |
| in_pad | input | N_IN | Input-only pad values |
| io_pad_in | input | N_IO | Input side of the tri-state pads |
| core_out | input | N_IO | Core data for the tri-state pads |
| core_oe | input | N_IO | Core output enables for the tri-state pads |
| pad_out | output | N_IO | Data driven toward the pads |
| pad_oe | output | N_IO | Output enables toward the pads |

## Verification
A wrong controller state shows on `so_oe` at the next falling edge and as a shifted data length of the wrong size at the end of the scan. A wrong instruction shows as the pads following the core instead of the latches (or the reverse) as soon as Update-IR completes. A misplaced boundary cell corrupts the captured vector on the very next data scan. A missed programming-mode entry shows as an asserted `pad_oe` one `sclk` edge after `mode_sel` falls. A wrongly held or shifted programming register is caught bit by bit when its contents are shifted back out on `so`.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
    localparam int IR_W = 2;
    localparam logic [IR_W-1:0] OP_EXTEST = 2'b00;
    localparam logic [IR_W-1:0] OP_SAMPLE = 2'b01;
    localparam logic [IR_W-1:0] OP_BYPASS = 2'b11;
    localparam logic [IR_W-1:0] IR_CAPT   = 2'b01;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_st_e;

    function automatic tap_st_e tap_next(input tap_st_e s, input logic m);
        case (s)
            ST_TLR:    return m ? ST_TLR    : ST_RTI;
            ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  return m ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  return m ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
            default:   return m ? ST_SEL_DR : ST_RTI;
        endcase
    endfunction
endpackage

// File: rtl/dtp_tap_fsm.sv
module dtp_tap_fsm
    import dtp_pkg::*;
(
    input  logic    clk,
    input  logic    trst_n,
    input  logic    run,
    input  logic    tms,
    output tap_st_e st
);
    tap_st_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) st_d = tap_next(st_q, tms);
    end

    always_ff @(posedge clk or negedge trst_n) begin
        if (!trst_n) st_q <= ST_TLR;
        else         st_q <= st_d;
    end

    assign st = st_q;

    // R2: reset state is absorbing while the select pin stays high
    a_r2_tlr_hold: assert property (@(posedge clk) disable iff (!trst_n)
        (run && tms && st_q == ST_TLR) |=> (st_q == ST_TLR));
    // R2: leaving Select-IR with the select pin high reaches reset
    a_r2_sel_ir_exit: assert property (@(posedge clk) disable iff (!trst_n)
        (run && tms && st_q == ST_SEL_IR) |=> (st_q == ST_TLR));
    // R11: frozen while the pins serve the programming path
    a_r11_frozen: assert property (@(posedge clk) disable iff (!trst_n)
        (!run) |=> $stable(st_q));
endmodule

// File: rtl/dtp_cap_cell.sv
module dtp_cap_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic cap,
    input  logic shift,
    input  logic pi,
    input  logic si,
    output logic sq
);
    logic sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (cap)        sh_d = pi;
        else if (shift) sh_d = si;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= 1'b0;
        else        sh_q <= sh_d;
    end

    assign sq = sh_q;
endmodule

// File: rtl/dtp_drv_cell.sv
module dtp_drv_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic cap,
    input  logic shift,
    input  logic upd,
    input  logic pi,
    input  logic si,
    output logic sq,
    output logic uq
);
    logic up_d, up_q;

    dtp_cap_cell u_stage (
        .clk(clk), .rst_n(rst_n), .cap(cap), .shift(shift),
        .pi(pi), .si(si), .sq(sq)
    );

    always_comb begin
        up_d = up_q;
        if (upd) up_d = sq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) up_q <= 1'b0;
        else        up_q <= up_d;
    end

    assign uq = up_q;
endmodule

// File: rtl/dtp_bs_chain.sv
module dtp_bs_chain #(
    parameter int N_IO = 4,
    parameter int N_IN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap,
    input  logic            shift,
    input  logic            upd,
    input  logic            tdi,
    input  logic [N_IN-1:0] in_pad,
    input  logic [N_IO-1:0] io_pad,
    input  logic [N_IO-1:0] core_out,
    input  logic [N_IO-1:0] core_oe,
    output logic            scan_out,
    output logic [N_IO-1:0] upd_out,
    output logic [N_IO-1:0] upd_oe
);
    localparam int L = N_IN + 3 * N_IO;

    logic [L-1:0] sq;
    logic [L-1:0] si;

    assign si       = {tdi, sq[L-1:1]};
    assign scan_out = sq[0];

    for (genvar k = 0; k < N_IN; k++) begin : g_in
        dtp_cap_cell u_in (
            .clk(clk), .rst_n(rst_n), .cap(cap), .shift(shift),
            .pi(in_pad[k]), .si(si[k]), .sq(sq[k])
        );
    end

    for (genvar j = 0; j < N_IO; j++) begin : g_io
        localparam int B = N_IN + 3 * j;
        dtp_cap_cell u_pin (
            .clk(clk), .rst_n(rst_n), .cap(cap), .shift(shift),
            .pi(io_pad[j]), .si(si[B]), .sq(sq[B])
        );
        dtp_drv_cell u_dat (
            .clk(clk), .rst_n(rst_n), .cap(cap), .shift(shift), .upd(upd),
            .pi(core_out[j]), .si(si[B+1]), .sq(sq[B+1]), .uq(upd_out[j])
        );
        dtp_drv_cell u_en (
            .clk(clk), .rst_n(rst_n), .cap(cap), .shift(shift), .upd(upd),
            .pi(core_oe[j]), .si(si[B+2]), .sq(sq[B+2]), .uq(upd_oe[j])
        );
    end
endmodule

// File: rtl/dual_test_port.sv
module dual_test_port
    import dtp_pkg::*;
#(
    parameter int N_IO   = 4,
    parameter int N_IN   = 2,
    parameter int PROG_W = 16
) (
    input  logic            mode_sel,
    input  logic            trst_n,
    input  logic            sclk,
    input  logic            ctl,
    input  logic            sdi,
    output logic            so,
    output logic            so_oe,
    input  logic [N_IN-1:0] in_pad,
    input  logic [N_IO-1:0] io_pad_in,
    input  logic [N_IO-1:0] core_out,
    input  logic [N_IO-1:0] core_oe,
    output logic [N_IO-1:0] pad_out,
    output logic [N_IO-1:0] pad_oe
);
    typedef struct packed {
        logic [IR_W-1:0] ir_sr;
        logic [IR_W-1:0] ir;
        logic            byp;
    } tst_t;

    typedef struct packed {
        logic [PROG_W-1:0] sr;
        logic              pm;
        logic              prev;
    } prg_t;

    typedef struct packed {
        logic d;
        logic oe;
    } tdo_t;

    tst_t    t_d, t_q;
    prg_t    p_d, p_q;
    tdo_t    o_d, o_q;
    tap_st_e st;

    logic            is_ext, is_smp, is_byp, bsel, bs_so;
    logic            bs_cap, bs_shift, bs_upd;
    logic [N_IO-1:0] upd_out, upd_oe;

    dtp_tap_fsm u_tap (
        .clk(sclk), .trst_n(trst_n), .run(mode_sel), .tms(ctl), .st(st)
    );

    assign is_ext = (t_q.ir == OP_EXTEST);
    assign is_smp = (t_q.ir == OP_SAMPLE);
    assign is_byp = !(is_ext || is_smp);
    assign bsel   = is_ext || is_smp;

    assign bs_cap   = mode_sel && bsel && (st == ST_CAP_DR);
    assign bs_shift = mode_sel && bsel && (st == ST_SH_DR);
    assign bs_upd   = mode_sel && bsel && (st == ST_UPD_DR);

    dtp_bs_chain #(.N_IO(N_IO), .N_IN(N_IN)) u_chain (
        .clk(sclk), .rst_n(trst_n), .cap(bs_cap), .shift(bs_shift), .upd(bs_upd),
        .tdi(sdi), .in_pad(in_pad), .io_pad(io_pad_in), .core_out(core_out),
        .core_oe(core_oe), .scan_out(bs_so), .upd_out(upd_out), .upd_oe(upd_oe)
    );

    // next values
    always_comb begin
        t_d = t_q;
        if (mode_sel) begin
            case (st)
                ST_TLR:    t_d.ir    = OP_BYPASS;
                ST_CAP_IR: t_d.ir_sr = IR_CAPT;
                ST_SH_IR:  t_d.ir_sr = {sdi, t_q.ir_sr[IR_W-1:1]};
                ST_UPD_IR: t_d.ir    = t_q.ir_sr;
                ST_CAP_DR: t_d.byp   = 1'b0;
                ST_SH_DR:  t_d.byp   = sdi;
                default:   ;
            endcase
        end

        p_d      = p_q;
        p_d.prev = mode_sel;
        p_d.pm   = !mode_sel && (p_q.pm || p_q.prev);
        if (!mode_sel && ctl) p_d.sr = {sdi, p_q.sr[PROG_W-1:1]};

        o_d.oe = (st == ST_SH_DR) || (st == ST_SH_IR);
        if (st == ST_SH_IR) o_d.d = t_q.ir_sr[0];
        else if (bsel)      o_d.d = bs_so;
        else                o_d.d = t_q.byp;
    end

    always_ff @(posedge sclk or negedge trst_n) begin
        if (!trst_n) t_q <= '{ir_sr: '0, ir: OP_BYPASS, byp: 1'b0};
        else         t_q <= t_d;
    end

    // programming state survives the test reset
    always_ff @(posedge sclk) begin
        p_q <= p_d;
    end

    always_ff @(negedge sclk or negedge trst_n) begin
        if (!trst_n) o_q <= '0;
        else         o_q <= o_d;
    end

    assign so      = mode_sel ? o_q.d  : p_q.sr[0];
    assign so_oe   = mode_sel ? o_q.oe : 1'b1;
    assign pad_out = is_ext ? upd_out : core_out;
    assign pad_oe  = p_q.pm ? '0 : (is_ext ? upd_oe : core_oe);

    // R10: a sampled fall of the select pin enters programming mode
    a_r10_enter: assert property (@(posedge sclk) disable iff (!trst_n)
        $fell(mode_sel) |=> p_q.pm);
    // R10: programming mode releases no pad enable
    a_r10_hiz: assert property (@(posedge sclk) disable iff (!trst_n)
        p_q.pm |-> (pad_oe == '0));
    // R8: scan output enabled only in the two shift states
    a_r8_oe_shift: assert property (@(posedge sclk) disable iff (!trst_n)
        (mode_sel && so_oe) |-> (st == ST_SH_DR || st == ST_SH_IR));
    // R4: an undefined code taken at Update-IR gives the bypass path
    a_r4_undef_byp: assert property (@(posedge sclk) disable iff (!trst_n)
        (mode_sel && st == ST_UPD_IR && t_q.ir_sr != OP_EXTEST && t_q.ir_sr != OP_SAMPLE)
        |=> is_byp);
    // R9: programming register holds when shifting is not enabled
    a_r9_hold: assert property (@(posedge sclk) disable iff (!trst_n)
        (!mode_sel && !ctl) |=> $stable(p_q.sr));
endmodule

// File: tb/tb_dual_test_port.sv
module tb_dual_test_port;
    localparam int N_IO = 4;
    localparam int N_IN = 2;
    localparam int PW   = 16;
    localparam int L    = N_IN + 3 * N_IO;

    logic mode_sel, trst_n, sclk, ctl, sdi, so, so_oe;
    logic [N_IN-1:0] in_pad;
    logic [N_IO-1:0] io_pad_in, core_out, core_oe, pad_out, pad_oe;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    dual_test_port #(.N_IO(N_IO), .N_IN(N_IN), .PROG_W(PW)) dut (
        .mode_sel(mode_sel), .trst_n(trst_n), .sclk(sclk), .ctl(ctl), .sdi(sdi),
        .so(so), .so_oe(so_oe), .in_pad(in_pad), .io_pad_in(io_pad_in),
        .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    initial sclk = 1'b0;
    always #5 sclk = ~sclk;

    // {instr, scan data, in_pad, io_pad_in, core_out, core_oe}
    localparam logic [29:0] VEC [6] = '{
        {2'b01, 14'h2A5C, 2'b10, 4'b0110, 4'b1011, 4'b1100},
        {2'b00, 14'h1234, 2'b01, 4'b1001, 4'b0101, 4'b0011},
        {2'b00, 14'h3FFF, 2'b11, 4'b0000, 4'b0000, 4'b0000},
        {2'b11, 14'h0F0F, 2'b01, 4'b1110, 4'b0001, 4'b1000},
        {2'b10, 14'h1555, 2'b10, 4'b0101, 4'b1100, 4'b0110},
        {2'b01, 14'h0000, 2'b11, 4'b1111, 4'b1111, 4'b1111}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [L-1:0] cap_model(input logic [N_IN-1:0] ip,
        input logic [N_IO-1:0] io, input logic [N_IO-1:0] co, input logic [N_IO-1:0] ce);
        logic [L-1:0] r;
        for (int k = 0; k < N_IN; k++) r[k] = ip[k];
        for (int j = 0; j < N_IO; j++) begin
            r[N_IN+3*j]   = io[j];
            r[N_IN+3*j+1] = co[j];
            r[N_IN+3*j+2] = ce[j];
        end
        return r;
    endfunction

    function automatic logic [N_IO-1:0] ext_out(input logic [L-1:0] d);
        logic [N_IO-1:0] r;
        for (int j = 0; j < N_IO; j++) r[j] = d[N_IN+3*j+1];
        return r;
    endfunction

    function automatic logic [N_IO-1:0] ext_oe(input logic [L-1:0] d);
        logic [N_IO-1:0] r;
        for (int j = 0; j < N_IO; j++) r[j] = d[N_IN+3*j+2];
        return r;
    endfunction

    // entered and left at rising edge + 2 ns; o is the bit leaving on this edge
    task automatic step(input logic t, input logic d, output logic o);
        ctl = t;
        sdi = d;
        @(negedge sclk); #3;
        o = so;
        @(posedge sclk); #2;
    endtask

    task automatic ir_scan(input logic [1:0] code, output logic [1:0] cap);
        logic o;
        step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 2; i++) begin
            step(i == 1, code[i], o);
            cap[i] = o;
        end
        step(1, 0, o); step(0, 0, o);
    endtask

    task automatic dr_scan(input int n, input logic [31:0] data, output logic [31:0] got);
        logic o;
        got = '0;
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, data[i], o);
            got[i] = o;
        end
        step(1, 0, o); step(0, 0, o);
    endtask

    initial begin
        repeat (20000) @(posedge sclk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0]  icap;
        logic [31:0] got;
        logic [15:0] pa, pb, pg;
        logic        o;
        logic [L-1:0] dx;

        mode_sel = 1; trst_n = 0; ctl = 1; sdi = 0;
        in_pad = 2'b01; io_pad_in = 4'b0011; core_out = 4'b0110; core_oe = 4'b1010;
        repeat (3) @(posedge sclk);
        #2 trst_n = 1;

        chk("R1 so_oe after reset", so_oe, 0);
        chk("R1 pad_oe follows core", pad_oe, 4'b1010);
        chk("R1 pad_out follows core", pad_out, 4'b0110);
        step(0, 0, o);

        ir_scan(2'b01, icap);
        chk("R3 IR capture value", icap, 2'b01);

        // reset selects the one-bit path
        trst_n = 0; @(posedge sclk); #2 trst_n = 1;
        step(0, 0, o);
        dr_scan(L + 1, 32'h2D5B, got);
        chk("R1 default bypass path", got, {17'b0, 14'h2D5B, 1'b0});

        for (int v = 0; v < 6; v++) begin
            logic [29:0] e;
            logic        bnd, ext;
            logic [L-1:0] d;
            e   = VEC[v];
            d   = e[27:14];
            in_pad = e[13:12]; io_pad_in = e[11:8]; core_out = e[7:4]; core_oe = e[3:0];
            ext = (e[29:28] == 2'b00);
            bnd = ext || (e[29:28] == 2'b01);
            ir_scan(e[29:28], icap);
            if (bnd) begin
                dr_scan(L, {18'b0, d}, got);
                chk("R7 boundary capture", got, {18'b0, cap_model(e[13:12], e[11:8], e[7:4], e[3:0])});
            end else begin
                dr_scan(L + 1, {18'b0, d}, got);
                chk("R4 one-bit path", got, {17'b0, d, 1'b0});
            end
            if (ext) begin
                chk("R6 pad_out from latches", pad_out, ext_out(d));
                chk("R6 pad_oe from latches", pad_oe, ext_oe(d));
            end else begin
                chk("R5 pad_out follows core", pad_out, e[7:4]);
                chk("R5 pad_oe follows core", pad_oe, e[3:0]);
            end
        end

        // R2: select pin held high returns to reset
        core_out = 4'b0000; core_oe = 4'b0000;
        ir_scan(2'b00, icap);
        dr_scan(L, 32'h3FFF, got);
        chk("R6 EXTEST enables", pad_oe, 4'b1111);
        for (int i = 0; i < 5; i++) step(1, 0, o);
        chk("R2 reset by select pin", pad_oe, 4'b0000);
        step(0, 0, o);

        // R8: enable only while shifting
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        @(negedge sclk); #3;
        chk("R8 so_oe in Shift-DR", so_oe, 1);
        @(posedge sclk); #2;
        step(1, 0, o); step(1, 0, o); step(0, 0, o);
        @(negedge sclk); #3;
        chk("R8 so_oe outside shift", so_oe, 0);
        @(posedge sclk); #2;

        // programming path with EXTEST loaded beforehand
        dx = 14'h24B6;
        core_oe = 4'b0000;
        ir_scan(2'b00, icap);
        dr_scan(L, {18'b0, dx}, got);
        ctl = 0;
        mode_sel = 0;
        @(posedge sclk); #2;
        chk("R10 pads released after fall", pad_oe, 4'b0000);
        chk("R9 so_oe in programming", so_oe, 1);
        pa = 16'hC3A5; pb = 16'h5E17;
        for (int i = 0; i < PW; i++) step(1, pa[i], o);
        for (int i = 0; i < 4; i++) step(0, 1, o);
        for (int i = 0; i < PW; i++) begin
            step(1, pb[i], o);
            pg[i] = o;
        end
        chk("R9 shift and hold A", pg, pa);
        for (int i = 0; i < PW; i++) begin
            step(1, 0, o);
            pg[i] = o;
        end
        chk("R9 readback B", pg, pb);
        chk("R10 pads still off", pad_oe, 4'b0000);
        ctl = 0;
        mode_sel = 1;
        @(posedge sclk); #2;
        chk("R11 instruction kept", pad_oe, ext_oe(dx));
        chk("R11 pad_out kept", pad_out, ext_out(dx));

        // test reset inside programming mode
        mode_sel = 0;
        @(posedge sclk); #2;
        trst_n = 0;
        @(posedge sclk); #2;
        chk("R10 trst keeps pads off", pad_oe, 4'b0000);
        trst_n = 1;
        @(posedge sclk); #2;
        chk("R10 still off after trst", pad_oe, 4'b0000);
        core_oe = 4'b0101;
        mode_sel = 1;
        @(posedge sclk); #2;
        chk("R1 reset cleared instruction", pad_oe, 4'b0101);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule